// File: doc/BRIEF.md
# Position-Frame Serial Transmitter

This block is the slave end of a clocked, point-to-point position link. A master toggles a serial clock line; the block answers on a single data line. While the link is idle the data line is held high. The first falling edge of the master clock captures a snapshot of the angle word, the period count, two error flags and the frame configuration. From then on each rising edge of the master clock places one bit on the data line. The frame carries the period count, the angle, the amplitude error flag, the frequency error flag, an inverted check sequence and, optionally, a one-bit zero placeholder.

The frame layout is chosen per frame. The period count can be left out or be 8, 12 or 24 bits long. The angle is 3 to 13 bits wide. The check sequence is 5 or 6 bits long, and the width of the count selects which one is used. When the master clock stops for longer than a selectable window, the block ends the frame, drives the line high again and waits for the next frame. All logic runs on one system clock. The master clock is sampled as data, and the window is counted in system cycles scaled by a reference divider.

Top module: `sensor_frame_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the data line `slo_o` is high and the block is idle.
- R2: A falling edge on `ma_i` while idle starts a frame. `slo_o` goes low one system clock after the edge is sampled. Every data and configuration input is captured at that edge, so changes made later have no effect on the frame.
- R3: Bits leave in this order: period count, angle, amplitude error flag (1 = error), frequency error flag (1 = error), check sequence, then the placeholder. Each multi-bit field is sent MSB first, and each rising `ma_i` edge presents the next bit one system clock after the edge is sampled.
- R4: `cfg_pc_mode_i` sets the length of the period count: 0 = none, 1 = 8 bits, 2 = 12 bits, 3 = 24 bits. The low bits of `pc_i` are sent. With `EXT_PC` = 0, codes 2 and 3 behave like code 1.
- R5: `cfg_ang_w_i` sets the angle width. Values below 3 are treated as 3 and values above 13 as 13. The low bits of `ang_i` are sent.
- R6: The check sequence covers every count, angle and flag bit of the frame. It is computed MSB first from an all-zero seed and is sent inverted, MSB first. Count codes 0 and 1 use the 5-bit polynomial x^5+x^2+1. Codes 2 and 3 use the 6-bit polynomial x^6+x+1.
- R7: With `cfg_ver_c_i` = 1, a single 0 placeholder bit follows the check sequence, except when the count is 24 bits long. With `cfg_ver_c_i` = 0 it is never sent.
- R8: A rising edge that arrives after the last frame bit drives `slo_o` low.
- R9: During a frame, if no `ma_i` edge is sampled for W = U x `REF_DIV` system cycles, `slo_o` returns high and the block goes idle. U is 256, 32, 8 or 2 for captured `cfg_tmo_i` codes 0, 1, 2 and 3.
- R10: An `ma_i` edge sampled in the cycle the window would expire keeps the frame going and restarts the window.
- R11: A rising `ma_i` edge while idle does not start a frame, and `slo_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ma_i | input | 1 | Master serial clock, sampled as data |
| pc_i | input | 24 | Period count value |
| ang_i | input | 13 | Angle value |
| err_amp_i | input | 1 | Amplitude error flag |
| err_frq_i | input | 1 | Frequency error flag |
| cfg_pc_mode_i | input | 2 | Period count length code |
| cfg_ang_w_i | input | 4 | Angle width in bits |
| cfg_ver_c_i | input | 1 | Enables the placeholder bit |
| cfg_tmo_i | input | 2 | Timeout window code |
| slo_o | output | 1 | Serial data line |

## Verification
The window expiry and a master clock edge can be sampled in the same system cycle. The bench provokes this by holding the master clock still for exactly W cycles after a frame bit and then driving a falling edge that is sampled on the expiring cycle. In that frame the following bits are zeros. A correct design keeps the frame alive and presents the next 0 on the following rise. A design that lets expiry win would show the idle-high level instead, and the bench reports that as a mismatch.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int PC_MAX  = 24;
    localparam int ANG_MAX = 13;
    localparam int ANG_MIN = 3;
    localparam int CRC_MAX = 6;
    localparam int DATA_W  = PC_MAX + ANG_MAX + 2;
    localparam int FRAME_W = DATA_W + CRC_MAX + 1;
    localparam int POS_W   = $clog2(FRAME_W + 1);

    localparam logic [4:0] POLY_NARROW_LO = 5'h05;
    localparam logic [5:0] POLY_WIDE_LO   = 6'h03;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } link_st_e;

    typedef enum logic [1:0] {
        PCM_NONE,
        PCM_8,
        PCM_12,
        PCM_24
    } pc_mode_e;

    typedef struct packed {
        logic [PC_MAX-1:0]  pc;
        logic [ANG_MAX-1:0] ang;
        logic               e_amp;
        logic               e_frq;
        pc_mode_e           mode;
        logic [3:0]         ang_w;
        logic               ver_c;
        logic [1:0]         tmo;
    } snap_t;

    function automatic logic [POS_W-1:0] pc_len(pc_mode_e m, bit ext);
        case (m)
            PCM_NONE: pc_len = POS_W'(0);
            PCM_8:    pc_len = POS_W'(8);
            PCM_12:   pc_len = ext ? POS_W'(12) : POS_W'(8);
            default:  pc_len = ext ? POS_W'(24) : POS_W'(8);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] ang_len(logic [3:0] w);
        if (w < 4'(ANG_MIN))
            ang_len = POS_W'(ANG_MIN);
        else if (w > 4'(ANG_MAX))
            ang_len = POS_W'(ANG_MAX);
        else
            ang_len = POS_W'(w);
    endfunction

    function automatic logic [8:0] tmo_units(logic [1:0] code);
        case (code)
            2'd0:    tmo_units = 9'd256;
            2'd1:    tmo_units = 9'd32;
            2'd2:    tmo_units = 9'd8;
            default: tmo_units = 9'd2;
        endcase
    endfunction

endpackage

// File: rtl/sft_edge.sv
module sft_edge (
    input  logic clk,
    input  logic rst,
    input  logic ma_i,
    output logic fall,
    output logic rise
);
    logic ma_q;

    always_ff @(posedge clk) begin
        if (rst)
            ma_q <= 1'b1;
        else
            ma_q <= ma_i;
    end

    assign fall = ma_q & ~ma_i;
    assign rise = ~ma_q & ma_i;
endmodule

// File: rtl/sft_timer.sv
module sft_timer import sft_pkg::*; #(
    parameter int REF_DIV = 32,
    parameter int TMO_W   = $clog2(256 * REF_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [1:0]       code,
    output logic [TMO_W-1:0] cnt,
    output logic [TMO_W-1:0] lim,
    output logic             expire
);
    assign lim = TMO_W'(32'(tmo_units(code)) * REF_DIV);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expire = run && !restart && (cnt == lim - 1'b1);
endmodule

// File: rtl/sft_crc.sv
module sft_crc import sft_pkg::*; #(
    parameter int         W       = 5,
    parameter logic [W-1:0] POLY_LO = W'(5)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [POS_W-1:0]  len,
    output logic [W-1:0]      crc
);
    logic [W-1:0] r;
    logic         fb;

    always_comb begin
        r  = '0;
        fb = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (i < int'(len)) begin
                fb = data[i] ^ r[W-1];
                r  = {r[W-2:0], 1'b0};
                if (fb)
                    r = r ^ POLY_LO;
            end
        end
        crc = r;
    end
endmodule

// File: rtl/sft_framer.sv
module sft_framer import sft_pkg::*; #(
    parameter bit EXT_PC = 1'b1
) (
    input  snap_t              snap,
    output logic [FRAME_W-1:0] frame,
    output logic [POS_W-1:0]   total
);
    logic [POS_W-1:0]   pcl, al, dlen, shamt;
    logic [DATA_W-1:0]  data;
    logic [4:0]         crc_n;
    logic [5:0]         crc_w;
    logic [5:0]         chk;
    logic [2:0]         cw;
    logic               wide, mcd;
    logic [FRAME_W-1:0] tail;

    assign pcl  = pc_len(snap.mode, EXT_PC);
    assign al   = ang_len(snap.ang_w);
    assign dlen = pcl + al + POS_W'(2);
    assign wide = EXT_PC && (snap.mode == PCM_12 || snap.mode == PCM_24);
    assign mcd  = snap.ver_c && !(EXT_PC && snap.mode == PCM_24);

    always_comb begin
        data = '0;
        for (int i = PC_MAX - 1; i >= 0; i--)
            if (i < int'(pcl))
                data = {data[DATA_W-2:0], snap.pc[i]};
        for (int i = ANG_MAX - 1; i >= 0; i--)
            if (i < int'(al))
                data = {data[DATA_W-2:0], snap.ang[i]};
        data = {data[DATA_W-2:0], snap.e_amp};
        data = {data[DATA_W-2:0], snap.e_frq};
    end

    sft_crc #(.W(5), .POLY_LO(POLY_NARROW_LO)) u_crc_n (
        .data(data), .len(dlen), .crc(crc_n)
    );

    generate
        if (EXT_PC) begin : g_wide
            sft_crc #(.W(6), .POLY_LO(POLY_WIDE_LO)) u_crc_w (
                .data(data), .len(dlen), .crc(crc_w)
            );
        end else begin : g_narrow_only
            assign crc_w = '0;
        end
    endgenerate

    always_comb begin
        cw   = wide ? 3'd6 : 3'd5;
        chk  = wide ? ~crc_w : {1'b0, ~crc_n};
        tail = FRAME_W'(data);
        tail = (tail << cw) | FRAME_W'(chk);
        if (mcd)
            tail = tail << 1;
        total = dlen + POS_W'(cw) + POS_W'(mcd);
        shamt = POS_W'(FRAME_W) - total;
        frame = tail << shamt;
    end
endmodule

// File: rtl/sensor_frame_tx.sv
module sensor_frame_tx import sft_pkg::*; #(
    parameter int REF_DIV = 32,
    parameter bit EXT_PC  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ma_i,
    input  logic [23:0] pc_i,
    input  logic [12:0] ang_i,
    input  logic        err_amp_i,
    input  logic        err_frq_i,
    input  logic [1:0]  cfg_pc_mode_i,
    input  logic [3:0]  cfg_ang_w_i,
    input  logic        cfg_ver_c_i,
    input  logic [1:0]  cfg_tmo_i,
    output logic        slo_o
);
    localparam int TMO_W = $clog2(256 * REF_DIV + 1);

    logic               fall, rise, expire, active;
    link_st_e           st_q;
    snap_t              snap_q, snap_d;
    logic [POS_W-1:0]   pos_q, total;
    logic [FRAME_W-1:0] frame, frame_sh;
    logic [TMO_W-1:0]   tmo_cnt, tmo_lim;
    logic               slo_q;

    sft_edge u_edge (
        .clk(clk), .rst(rst), .ma_i(ma_i), .fall(fall), .rise(rise)
    );

    assign active = (st_q == ST_ACTIVE);

    sft_timer #(.REF_DIV(REF_DIV), .TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .run(active), .restart(fall | rise),
        .code(snap_q.tmo), .cnt(tmo_cnt), .lim(tmo_lim), .expire(expire)
    );

    sft_framer #(.EXT_PC(EXT_PC)) u_framer (
        .snap(snap_q), .frame(frame), .total(total)
    );

    always_comb begin
        snap_d.pc    = pc_i;
        snap_d.ang   = ang_i;
        snap_d.e_amp = err_amp_i;
        snap_d.e_frq = err_frq_i;
        snap_d.mode  = pc_mode_e'(cfg_pc_mode_i);
        snap_d.ang_w = cfg_ang_w_i;
        snap_d.ver_c = cfg_ver_c_i;
        snap_d.tmo   = cfg_tmo_i;
    end

    assign frame_sh = frame << pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            snap_q <= '0;
            pos_q  <= '0;
            slo_q  <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    slo_q <= 1'b1;
                    if (fall) begin
                        st_q   <= ST_ACTIVE;
                        snap_q <= snap_d;
                        pos_q  <= '0;
                        slo_q  <= 1'b0;
                    end
                end
                default: begin
                    if (expire) begin
                        st_q  <= ST_IDLE;
                        slo_q <= 1'b1;
                    end else if (rise) begin
                        if (pos_q < total) begin
                            slo_q <= frame_sh[FRAME_W-1];
                            pos_q <= pos_q + 1'b1;
                        end else begin
                            slo_q <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    assign slo_o = slo_q;
endmodule

// File: rtl/sensor_frame_tx_chk.sv
module sensor_frame_tx_chk import sft_pkg::*; #(
    parameter int TW = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             slo_o,
    input link_st_e         st,
    input logic             fall,
    input logic             rise,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] total,
    input logic [TW-1:0]    tmo_cnt,
    input logic [TW-1:0]    tmo_lim
);
    // R1
    a_r1_reset_idle_high: assert property (@(posedge clk)
        rst |=> (slo_o && st == ST_IDLE));

    // R2
    a_r2_start_pulls_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && fall) |=> (!slo_o && st == ST_ACTIVE));

    // R11
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !fall) |=> (slo_o && st == ST_IDLE));

    // R3
    a_r3_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE) |-> (pos <= total));

    // R8
    a_r8_tail_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE && rise && pos >= total) |=> !slo_o);

    // R9
    a_r9_window_bounded: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE) |-> (tmo_cnt < tmo_lim));

    // R10
    a_r10_edge_keeps_frame: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACTIVE && (rise || fall)) |=> (st == ST_ACTIVE));
endmodule

bind sensor_frame_tx sensor_frame_tx_chk #(.TW(TMO_W)) u_chk (
    .clk(clk), .rst(rst), .slo_o(slo_o), .st(st_q), .fall(fall), .rise(rise),
    .pos(pos_q), .total(total), .tmo_cnt(tmo_cnt), .tmo_lim(tmo_lim)
);

// File: tb/sensor_frame_tx_bench.sv
`timescale 1ns/1ps
module sensor_frame_tx_bench;
    localparam int RDIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ma = 1'b1;
    logic [23:0] pc = '0;
    logic [12:0] ang = '0;
    logic        ea = 1'b0, ef = 1'b0;
    logic [1:0]  mode = '0;
    logic [3:0]  aw = '0;
    logic        ver = 1'b0;
    logic [1:0]  tmo = '0;
    logic        slo;

    int vectors = 0;
    int fails = 0;

    bit    exp_bit [64];
    string exp_tag [64];
    int    nexp;

    always #5 clk = ~clk;

    sensor_frame_tx #(.REF_DIV(RDIV), .EXT_PC(1'b1)) u_sensor_frame_tx (
        .clk(clk), .rst(rst), .ma_i(ma), .pc_i(pc), .ang_i(ang),
        .err_amp_i(ea), .err_frq_i(ef), .cfg_pc_mode_i(mode),
        .cfg_ang_w_i(aw), .cfg_ver_c_i(ver), .cfg_tmo_i(tmo), .slo_o(slo)
    );

    task automatic check(input bit got, input bit want, input string tag, input string what);
        vectors++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, want);
        end
    endtask

    function automatic int window(input logic [1:0] c);
        int u;
        u = (c == 0) ? 256 : (c == 1) ? 32 : (c == 2) ? 8 : 2;
        return u * RDIV;
    endfunction

    task automatic push(input bit b, input string t);
        exp_bit[nexp] = b;
        exp_tag[nexp] = t;
        nexp++;
    endtask

    // Expected frame: R4 count, R5 angle, R3 flags, R6 inverted check, R7 placeholder
    task automatic build(input logic [23:0] p, input logic [12:0] a, input bit e1, input bit e0,
                         input logic [1:0] m, input logic [3:0] w, input bit v);
        int pl, al, cw, dl;
        longint msg, rem, poly;
        nexp = 0;
        msg = 0;
        pl = (m == 0) ? 0 : (m == 1) ? 8 : (m == 2) ? 12 : 24;
        al = (w < 3) ? 3 : (w > 13) ? 13 : int'(w);
        for (int i = pl - 1; i >= 0; i--) begin push(p[i], "R4"); msg = msg * 2 + longint'(p[i]); end
        for (int i = al - 1; i >= 0; i--) begin push(a[i], "R5"); msg = msg * 2 + longint'(a[i]); end
        push(e1, "R3"); msg = msg * 2 + longint'(e1);
        push(e0, "R3"); msg = msg * 2 + longint'(e0);
        dl = pl + al + 2;
        cw = (m >= 2) ? 6 : 5;
        poly = (cw == 6) ? 64'h43 : 64'h25;
        rem = msg << cw;
        for (int i = dl + cw - 1; i >= cw; i--)
            if (rem[i]) rem = rem ^ (poly << (i - cw));
        for (int i = cw - 1; i >= 0; i--) push(!rem[i], "R6");
        if (v && m != 3) push(1'b0, "R7");
    endtask

    task automatic run_frame(input logic [23:0] p, input logic [12:0] a, input bit e1, input bit e0,
                             input logic [1:0] m, input logic [3:0] w, input bit v,
                             input logic [1:0] t, input bit hold_r10, input bit end_low);
        int win;
        pc = p; ang = a; ea = e1; ef = e0; mode = m; aw = w; ver = v; tmo = t;
        build(p, a, e1, e0, m, w, v);
        win = window(t);
        @(negedge clk);
        ma = 1'b0;
        @(negedge clk);
        check(slo, 1'b0, "R2", "start level");
        pc = ~p; ang = ~a; ea = !e1; ef = !e0; mode = ~m; aw = ~w; ver = !v; tmo = ~t;
        for (int b = 0; b < nexp; b++) begin
            ma = 1'b1;
            @(negedge clk);
            check(slo, exp_bit[b], exp_tag[b], $sformatf("bit %0d", b));
            if (hold_r10 && b == 0) begin
                repeat (win - 1) @(negedge clk);
                ma = 1'b0;
                @(negedge clk);
                check(slo, exp_bit[0], "R10", "held at expiry");
            end else begin
                ma = 1'b0;
                @(negedge clk);
            end
        end
        ma = 1'b1;
        @(negedge clk);
        check(slo, 1'b0, "R8", "past end");
        if (end_low) begin
            ma = 1'b0;
            @(negedge clk);
        end
        repeat (win - 1) @(negedge clk);
        check(slo, 1'b0, "R9", "before window");
        @(negedge clk);
        check(slo, 1'b1, "R9", "after window");
        if (end_low) begin
            ma = 1'b1;
            repeat (4) @(negedge clk);
            check(slo, 1'b1, "R11", "rise while idle");
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(slo, 1'b1, "R1", "in reset");
        rst = 1'b0;
        @(negedge clk);
        check(slo, 1'b1, "R1", "after reset");

        // R10: count zero so the bit after the held edge is 0, not idle high
        run_frame(24'h0, 13'h1ABC, 1'b1, 1'b0, 2'd1, 4'd9, 1'b1, 2'd2, 1'b1, 1'b0);
        // R11: frame ends with clock low, then a rise arrives while idle
        run_frame(24'hC3A5F0, 13'h0F0F, 1'b0, 1'b1, 2'd2, 4'd13, 1'b0, 2'd3, 1'b0, 1'b1);

        for (int md = 0; md < 4; md++)
            for (int w = 0; w < 16; w++)
                for (int v = 0; v < 2; v++) begin
                    int idx;
                    logic [23:0] pv;
                    logic [12:0] av;
                    idx = md * 32 + w * 2 + v;
                    pv = 24'(idx * 32'h2F3B5) ^ 24'h9A61C7;
                    av = 13'(idx * 32'h0B7) ^ 13'h1A5C;
                    run_frame(pv, av, bit'(idx % 3 == 0), bit'((idx / 2) % 2),
                              2'(md), 4'(w), bit'(v), 2'(idx % 4), 1'b0, 1'b0);
                end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule